// File: doc/BRIEF.md
# Scatter Descriptor Table Builder

This block turns one block-transfer request into a table of scatter descriptors for an advanced DMA engine. A request gives a block size, a block count, a buffer start address and an address-mode select for 32-bit or 64-bit descriptors. The block multiplies size by count to get the transfer length. It then walks the buffer in chunks of at most 65532 bytes and emits one descriptor per chunk through a table write port. That port carries a slot index, the slot's byte offset in the table and the descriptor word.

Software or a sequencer pulses `start` while the block is idle. The block raises `busy` until the last descriptor is accepted. It then pulses `done` and holds the descriptor count until the next request. A request whose total length is zero writes nothing and completes at once with an error flag.

Top module: `sgt_builder`

## Requirements
- R1: The transfer length is `blk_size * blk_count`. On completion `desc_cnt` equals that length divided by 65532, rounded up.
- R2: Every descriptor except the last carries length 65532 in `wr_data[31:16]`. The last carries the remaining byte count, which is between 1 and 65532.
- R3: Descriptor k carries address `base + k*65532`. Its low 32 bits are in `wr_data[63:32]`. In 64-bit mode its high 32 bits are in `wr_data[95:64]`. In 32-bit mode `wr_data[127:64]` is zero, and in 64-bit mode `wr_data[127:96]` is zero.
- R4: The attribute byte `wr_data[7:0]` is 0x21 for every non-final descriptor: bit 0 valid, bit 5 set, bit 4 clear. It is 0x23 for the final descriptor, which adds the end bit, bit 1. `wr_data[15:8]` is zero.
- R5: `wr_slot` is 0 for the first descriptor of each request and rises by one per accepted descriptor. `wr_offset` is `wr_slot*8` in 32-bit mode and `wr_slot*16` in 64-bit mode.
- R6: A zero-length request writes no descriptor. One cycle after `start` it pulses `done` with `err_zero` high and `desc_cnt` 0.
- R7: A `start` pulse while `busy` is high is ignored. The running table is unchanged.
- R8: While `wr_valid` is high and `wr_ready` is low, the descriptor, slot and offset hold steady. With `wr_ready` high, one descriptor is accepted per cycle.
- R9: After reset, `busy`, `done`, `err_zero` and `wr_valid` are low and `desc_cnt` is 0.
- R10: `done` is a single-cycle pulse in the cycle after the final descriptor is accepted. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| blk_size | input | 16 | Bytes per block |
| blk_count | input | 16 | Number of blocks |
| base_addr | input | 64 | Buffer start address |
| mode64 | input | 1 | 1 selects 16-byte descriptors with a 64-bit address |
| busy | output | 1 | Table generation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_zero | output | 1 | Last request had zero length |
| desc_cnt | output | 17 | Descriptors written by the last request |
| wr_valid | output | 1 | Descriptor write pending |
| wr_ready | input | 1 | Table accepts the write this cycle |
| wr_slot | output | 17 | Descriptor index |
| wr_offset | output | 21 | Byte offset of the slot in the table |
| wr_data | output | 128 | Descriptor word |

## Verification
The in-RTL assertions check, on every cycle, the properties that hold for each write on its own. These are the attribute byte pattern, the full length on non-final entries, slot stepping and the hold of the word under back-pressure. They also check that `done` never overlaps `busy` or a pending write, and that an errored completion reports a count of zero. The count rounding, the exact final remainder, the address progression and 32-bit address wrap depend on the request as a whole, so only the bench's scenarios can show them. The bench sweeps several sizes and counts around the 65532 boundary in both modes, with and without back-pressure. The same holds for zero-length requests and for a `start` that arrives while busy.

// File: rtl/sgt_pkg.sv
package sgt_pkg;
    localparam int CHUNK_MAX = 65532;
    localparam int LEN_W     = 16;
    localparam int DESC_W    = 128;

    typedef enum logic {ST_IDLE, ST_EMIT} sgt_state_t;

    typedef struct packed {
        logic [31:0] pad;
        logic [31:0] addr_hi;
        logic [31:0] addr_lo;
        logic [15:0] len;
        logic [7:0]  rsvd;
        logic [7:0]  attr;
    } sgt_desc_t;

    function automatic logic [7:0] sgt_attr(input logic last);
        logic [7:0] a;
        a = 8'h21;
        if (last) a = a | 8'h02;
        return a;
    endfunction
endpackage

// File: rtl/sgt_chunker.sv
module sgt_chunker #(
    parameter int ADDR_W = 64,
    parameter int TOT_W  = 32,
    parameter int SLOT_W = 17,
    parameter int CHUNK  = 65532,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TOT_W-1:0]  total,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output logic [LEN_W-1:0]  cur_len,
    output logic              is_last
);
    localparam logic [TOT_W-1:0]  CHUNK_T = TOT_W'(CHUNK);
    localparam logic [ADDR_W-1:0] CHUNK_A = ADDR_W'(CHUNK);

    logic [TOT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            addr      <= '0;
            slot      <= '0;
        end else if (load) begin
            remaining <= total;
            addr      <= base;
            slot      <= '0;
        end else if (advance) begin
            remaining <= remaining - CHUNK_T;
            addr      <= addr + CHUNK_A;
            slot      <= slot + 1'b1;
        end
    end

    always_comb begin
        is_last = (remaining <= CHUNK_T);
        cur_len = is_last ? remaining[LEN_W-1:0] : LEN_W'(CHUNK);
    end
endmodule

// File: rtl/sgt_desc_pack.sv
module sgt_desc_pack
    import sgt_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SLOT_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              last,
    input  logic              wide,
    input  logic [SLOT_W-1:0] slot,
    output sgt_desc_t         desc,
    output logic [SLOT_W+3:0] offset
);
    always_comb begin
        desc         = '0;
        desc.attr    = sgt_attr(last);
        desc.len     = len;
        desc.addr_lo = addr[31:0];
        desc.addr_hi = wide ? addr[63:32] : 32'h0;
        offset       = wide ? {slot, 4'b0000} : {1'b0, slot, 3'b000};
    end
endmodule

// File: rtl/sgt_builder.sv
module sgt_builder
    import sgt_pkg::*;
#(
    parameter int BSZ_W  = 16,
    parameter int BCNT_W = 16,
    parameter int ADDR_W = 64,
    localparam int TOT_W  = BSZ_W + BCNT_W,
    localparam int SLOT_W = TOT_W - 15,
    localparam int OFF_W  = SLOT_W + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BSZ_W-1:0]  blk_size,
    input  logic [BCNT_W-1:0] blk_count,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              mode64,
    output logic              busy,
    output logic              done,
    output logic              err_zero,
    output logic [SLOT_W-1:0] desc_cnt,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [OFF_W-1:0]  wr_offset,
    output logic [DESC_W-1:0] wr_data
);
    sgt_state_t        st;
    logic              wide_q;
    logic [TOT_W-1:0]  req_total;
    logic              load, advance, last;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_len;
    sgt_desc_t         desc;

    assign req_total = TOT_W'(blk_size) * TOT_W'(blk_count);
    assign load      = (st == ST_IDLE) && start && (req_total != '0);
    assign advance   = (st == ST_EMIT) && wr_ready && !last;
    assign busy      = (st == ST_EMIT);
    assign wr_valid  = (st == ST_EMIT);
    assign wr_data   = desc;

    sgt_chunker #(.ADDR_W(ADDR_W), .TOT_W(TOT_W), .SLOT_W(SLOT_W),
                  .CHUNK(CHUNK_MAX), .LEN_W(LEN_W)) u_chunk (
        .clk(clk), .rst(rst), .load(load), .total(req_total),
        .base(base_addr), .advance(advance), .addr(cur_addr),
        .slot(wr_slot), .cur_len(cur_len), .is_last(last)
    );

    sgt_desc_pack #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_pack (
        .addr(cur_addr), .len(cur_len), .last(last), .wide(wide_q),
        .slot(wr_slot), .desc(desc), .offset(wr_offset)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            wide_q   <= 1'b0;
            done     <= 1'b0;
            err_zero <= 1'b0;
            desc_cnt <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    wide_q <= mode64;
                    if (req_total == '0) begin
                        done     <= 1'b1;
                        err_zero <= 1'b1;
                        desc_cnt <= '0;
                    end else begin
                        err_zero <= 1'b0;
                        st       <= ST_EMIT;
                    end
                end
                ST_EMIT: if (wr_ready && last) begin
                    st       <= ST_IDLE;
                    done     <= 1'b1;
                    desc_cnt <= wr_slot + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4: attribute byte and reserved byte
    a_r4_attr_bits: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_data[15:8] == 8'h00 && wr_data[0] && wr_data[5] && !wr_data[4]));
    // R2: non-final entries carry the full chunk
    a_r2_full_chunk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_data[1]) |-> (wr_data[31:16] == LEN_W'(CHUNK_MAX)));
    // R2: final entry length nonzero
    a_r2_last_nonzero: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_data[1]) |-> (wr_data[31:16] != '0));
    // R5: slot steps by one after an accepted non-final entry
    a_r5_slot_step: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && !wr_data[1]) |=> (wr_valid && wr_slot == $past(wr_slot) + 1'b1));
    // R8: back-pressure holds the write
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_slot) && $stable(wr_offset)));
    // R10: completion never overlaps activity
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !wr_valid));
    // R6: errored completion reports no descriptors
    a_r6_zero_cnt: assert property (@(posedge clk) disable iff (rst)
        (done && err_zero) |-> (desc_cnt == '0));
    // R3: narrow mode leaves the upper half empty
    a_r3_narrow_upper: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wide_q) |-> (wr_data[127:64] == '0));
endmodule

// File: tb/sim_sgt_builder.sv
module sim_sgt_builder;
    localparam int CH = 65532;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [15:0]  blk_size = '0;
    logic [15:0]  blk_count = '0;
    logic [63:0]  base_addr = '0;
    logic         mode64 = 1'b0;
    logic         busy, done, err_zero, wr_valid;
    logic         wr_ready = 1'b0;
    logic [16:0]  desc_cnt, wr_slot;
    logic [20:0]  wr_offset;
    logic [127:0] wr_data;

    int checks = 0, fails = 0, cyc = 0;
    longint e_total = 0, e_n = 0;
    logic [63:0] e_base = '0;
    logic        e_m64 = 1'b0;
    int          idx = 0;
    int          stall_on = 0;
    logic        held = 1'b0;
    logic [127:0] held_data = '0;

    always #5 clk = ~clk;

    sgt_builder u0 (
        .clk(clk), .rst(rst), .start(start), .blk_size(blk_size),
        .blk_count(blk_count), .base_addr(base_addr), .mode64(mode64),
        .busy(busy), .done(done), .err_zero(err_zero), .desc_cnt(desc_cnt),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_slot(wr_slot),
        .wr_offset(wr_offset), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_desc(input int k);
        longint      len;
        logic [63:0] a;
        logic [7:0]  attr;
        len  = (k < e_n - 1) ? CH : e_total - (e_n - 1) * CH;
        a    = e_base + 64'(k) * 64'(CH);
        attr = (k == e_n - 1) ? 8'h23 : 8'h21;
        return {32'h0, e_m64 ? a[63:32] : 32'h0, a[31:0], 16'(len), 8'h00, attr};
    endfunction

    always @(negedge clk) begin
        logic rdy;
        cyc++;
        rdy = (stall_on != 0) ? ((cyc % 3) != 1) : 1'b1;
        wr_ready = rdy;
        if (held) begin
            chk(wr_valid && wr_data == held_data, "R8 hold", longint'(wr_data[63:0]), longint'(held_data[63:0]));
            held = 1'b0;
        end
        if (!rst && wr_valid) begin
            if (rdy) begin
                logic [127:0] e;
                e = exp_desc(idx);
                chk(wr_data[31:16] == e[31:16], "R2 len", longint'(wr_data[31:16]), longint'(e[31:16]));
                chk(wr_data[127:32] == e[127:32], "R3 addr", longint'(wr_data[95:32]), longint'(e[95:32]));
                chk(wr_data[15:0] == e[15:0], "R4 attr", longint'(wr_data[15:0]), longint'(e[15:0]));
                chk(wr_slot == 17'(idx), "R5 slot", longint'(wr_slot), idx);
                chk(wr_offset == 21'(idx * (e_m64 ? 16 : 8)), "R5 offset", longint'(wr_offset), idx * (e_m64 ? 16 : 8));
                idx++;
            end else begin
                held = 1'b1;
                held_data = wr_data;
            end
        end
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_case(input int bs, input int bc, input logic [63:0] b, input logic m, input int stl, input bit intrude);
        int w;
        @(negedge clk);
        stall_on = stl;
        blk_size = 16'(bs); blk_count = 16'(bc); base_addr = b; mode64 = m;
        e_total = longint'(bs) * longint'(bc);
        e_n = (e_total + CH - 1) / CH;
        e_base = b; e_m64 = m; idx = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            @(negedge clk);
            chk(busy, "R7 busy", longint'(busy), 1);
            blk_size = 16'd1; blk_count = 16'd1; base_addr = 64'h0; mode64 = ~m;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 100000) begin @(negedge clk); w++; end
        chk(done, "R10 done seen", longint'(done), 1);
        chk(!busy, "R10 busy low", longint'(busy), 0);
        chk(err_zero == (e_total == 0), "R6 err", longint'(err_zero), longint'(e_total == 0));
        chk(desc_cnt == 17'(e_n), "R1 count", longint'(desc_cnt), e_n);
        chk(idx == e_n, intrude ? "R7 writes" : "R1 writes", idx, e_n);
        @(negedge clk);
        chk(!done, "R10 pulse", longint'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err_zero && !wr_valid && desc_cnt == 0, "R9 reset", longint'({busy, done, err_zero, wr_valid}), 0);
        rst = 1'b0;
        run_case(512, 1, 64'h1000, 1'b0, 0, 0);
        run_case(512, 128, 64'h1_2345_0000, 1'b1, 0, 0);
        run_case(65532, 1, 64'h40, 1'b0, 0, 0);
        run_case(65532, 2, 64'h8000_0000_0000, 1'b1, 1, 0);
        run_case(4, 16383, 64'h0, 1'b1, 0, 0);
        run_case(1, 65533, 64'h10, 1'b0, 1, 0);
        run_case(0, 5, 64'h0, 1'b0, 0, 0);
        run_case(5, 0, 64'h0, 1'b1, 0, 0);
        run_case(512, 300, 64'hFFFF_0000, 1'b0, 1, 1);
        run_case(512, 300, 64'hFFFF_FFFF_FFFF_0000, 1'b1, 0, 1);
        for (int bc = 1; bc <= 8; bc++) begin
            run_case(30000, bc, 64'h3_0000_0004 * 64'(bc), 1'(bc % 2), bc % 2, 0);
            run_case(65535, bc, 64'h100, 1'(bc / 2 % 2), 1, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule